// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This block rearranges the elements of one vector register under a per-element enable mask. In compress mode it gathers the elements whose mask bit is set and packs them, in their original order, into the lowest positions of the result. It also reports how many elements were packed. In expand mode it does the opposite: it takes the lowest source elements in order and places them into the positions whose mask bit is set. Every other position keeps the value it had in the old destination vector.

The block works sequentially, one element per clock. A running count of the set mask bits seen so far steers each element to its place. A caller raises a one-cycle start together with the opcode, the source vector, the old destination vector and the mask. It then waits for a one-cycle done pulse, after which the result and the packed length stay stable until the next accepted start. The register file that holds the vectors is outside the block.

Top module: `vmask_pack_unit`

## Requirements
- R1: After reset, done_o is 0, result_o is all zeros and packed_len_o is 0.
- R2: With opcode_i = 0 (compress), the j-th element in result_o (element e occupies bits e*ELEM_W upward) is the source element at the position of the j-th set mask bit, counting from bit 0, for every j below the packed length.
- R3: When done_o is high, packed_len_o equals the number of set bits in the mask of that operation, for both opcodes.
- R4: In compress, every result element at index packed_len_o and above is zero.
- R5: With opcode_i = 1 (expand), the result element at the position of the k-th set mask bit equals source element k.
- R6: In expand, every result element whose mask bit is clear equals the same element of the old destination vector.
- R7: done_o rises exactly NUM_ELEM+1 clock edges after the edge that accepts start_i, and stays high for exactly one cycle.
- R8: A start_i raised while an operation is in progress is ignored, together with its operands; the running operation completes with its original inputs.
- R9: Between done_o and the next accepted start, result_o and packed_len_o hold their values whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to begin an operation; taken only when idle |
| opcode_i | input | 1 | 0 = compress, 1 = expand |
| src_i | input | NUM_ELEM*ELEM_W | Source vector, element e at bits e*ELEM_W upward |
| old_dst_i | input | NUM_ELEM*ELEM_W | Previous destination contents, merged in expand |
| mask_i | input | NUM_ELEM | Per-element enable, bit e for element e |
| done_o | output | 1 | One-cycle pulse marking a finished operation |
| result_o | output | NUM_ELEM*ELEM_W | Result vector |
| packed_len_o | output | $clog2(NUM_ELEM+1) | Count of set mask bits of the last operation |

## Verification
The assertions assume that the operand inputs matter only in the cycle where start_i is accepted. They also assume that start_i may arrive at any time, including while an operation runs. The bench drives random operands and opcodes on every idle cycle after done to exercise the hold behaviour. It also raises start_i with fresh random operands in the middle of some runs. Masks cover random values plus the directed all-clear, all-set, single-low-bit, single-high-bit and alternating patterns, so the packed length reaches both 0 and NUM_ELEM.

// File: rtl/vmx_pkg.sv
// Shared types for the mask compress/expand unit.
// Assumes a 1-bit opcode; the encoding is visible at the top port.
package vmx_pkg;
    typedef enum logic {
        OP_COMPRESS = 1'b0,
        OP_EXPAND   = 1'b1
    } vmx_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } vmx_state_e;
endpackage

// File: rtl/vmx_seq.sv
// Sequencer: accepts start when idle, walks the element index once over
// all NUM_ELEM elements, then spends one finish cycle and pulses done.
// Assumes start_i is a level sampled each edge; requests while busy are dropped.
module vmx_seq #(
    parameter int NUM_ELEM = 8,
    localparam int IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             load_o,
    output logic             step_o,
    output logic             busy_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             done_o
);
    import vmx_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ELEM - 1);

    vmx_state_e state_q;
    logic [IDX_W-1:0] idx_q;
    logic done_q;

    // Decode the handshake strobes from the current state.
    always_comb begin
        load_o = start_i && (state_q == ST_IDLE);
        step_o = (state_q == ST_RUN);
        busy_o = (state_q != ST_IDLE);
    end

    // Advance the state, the element index and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RUN;
                        idx_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= ST_FIN;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign idx_o  = idx_q;
    assign done_o = done_q;
endmodule

// File: rtl/vmx_prefix.sv
// Running exclusive prefix count of the mask: before each step it holds the
// number of set bits below the current index; after the last step it holds
// the population count. Assumes one mask bit is presented per step.
module vmx_prefix #(
    parameter int NUM_ELEM = 8,
    localparam int CNT_W = $clog2(NUM_ELEM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             bit_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] count_q;

    // Clear on a new operation, add the current mask bit on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= '0;
        end else if (step_i) begin
            count_q <= count_q + CNT_W'(bit_i);
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/vmx_lanes.sv
// Operand capture and result register. On load it latches the operands and
// seeds the result (zeros for compress, old destination for expand). On each
// step with an active mask bit it moves one element, using the prefix count
// as the packed-side index. Assumes pos_i < NUM_ELEM whenever the bit is set.
module vmx_lanes #(
    parameter int ELEM_W   = 32,
    parameter int NUM_ELEM = 8,
    localparam int IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
    localparam int VEC_W = ELEM_W * NUM_ELEM
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                step_i,
    input  vmx_pkg::vmx_op_e    op_i,
    input  logic [VEC_W-1:0]    src_i,
    input  logic [VEC_W-1:0]    old_i,
    input  logic [NUM_ELEM-1:0] mask_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [IDX_W-1:0]    pos_i,
    output logic                bit_o,
    output logic [NUM_ELEM-1:0] mask_o,
    output vmx_pkg::vmx_op_e    op_o,
    output logic [VEC_W-1:0]    result_o
);
    import vmx_pkg::*;

    logic [ELEM_W-1:0] src_q [NUM_ELEM];
    logic [ELEM_W-1:0] res_q [NUM_ELEM];
    logic [NUM_ELEM-1:0] mask_q;
    vmx_op_e op_q;

    // Capture operands on load, then move one element per active step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM_ELEM; e++) begin
                src_q[e] <= '0;
                res_q[e] <= '0;
            end
            mask_q <= '0;
            op_q   <= OP_COMPRESS;
        end else if (load_i) begin
            for (int e = 0; e < NUM_ELEM; e++) begin
                src_q[e] <= src_i[e*ELEM_W +: ELEM_W];
                res_q[e] <= (op_i == OP_EXPAND) ? old_i[e*ELEM_W +: ELEM_W] : '0;
            end
            mask_q <= mask_i;
            op_q   <= op_i;
        end else if (step_i && mask_q[idx_i]) begin
            if (op_q == OP_COMPRESS) begin
                res_q[pos_i] <= src_q[idx_i];
            end else begin
                res_q[idx_i] <= src_q[pos_i];
            end
        end
    end

    // Flatten the result array onto the output vector.
    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_flat
        assign result_o[g*ELEM_W +: ELEM_W] = res_q[g];
    end

    assign bit_o  = mask_q[idx_i];
    assign mask_o = mask_q;
    assign op_o   = op_q;
endmodule

// File: rtl/vmask_pack_unit.sv
// Top of the mask compress/expand unit: sequencer, prefix counter and
// element lanes. An operation takes NUM_ELEM+1 edges from accepted start
// to done. Assumes operands are valid in the cycle start_i is accepted.
module vmask_pack_unit #(
    parameter int ELEM_W   = 32,
    parameter int NUM_ELEM = 8,
    localparam int IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
    localparam int CNT_W = $clog2(NUM_ELEM + 1),
    localparam int VEC_W = ELEM_W * NUM_ELEM
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                opcode_i,
    input  logic [VEC_W-1:0]    src_i,
    input  logic [VEC_W-1:0]    old_dst_i,
    input  logic [NUM_ELEM-1:0] mask_i,
    output logic                done_o,
    output logic [VEC_W-1:0]    result_o,
    output logic [CNT_W-1:0]    packed_len_o
);
    import vmx_pkg::*;

    logic load, step, busy, cur_bit;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] count;
    logic [NUM_ELEM-1:0] cur_mask;
    vmx_op_e cur_op;

    vmx_seq #(.NUM_ELEM(NUM_ELEM)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .load_o(load), .step_o(step), .busy_o(busy),
        .idx_o(idx), .done_o(done_o)
    );

    vmx_prefix #(.NUM_ELEM(NUM_ELEM)) u_prefix (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
        .bit_i(cur_bit), .count_o(count)
    );

    vmx_lanes #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM)) u_lanes (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
        .op_i(vmx_op_e'(opcode_i)), .src_i(src_i), .old_i(old_dst_i),
        .mask_i(mask_i), .idx_i(idx), .pos_i(count[IDX_W-1:0]),
        .bit_o(cur_bit), .mask_o(cur_mask), .op_o(cur_op),
        .result_o(result_o)
    );

    assign packed_len_o = count;
endmodule

// File: rtl/vmx_checker.sv
// Property checker for the compress/expand unit, bound to the top module.
// Assumes inputs may change freely; only accepted starts load operands.
module vmx_checker #(
    parameter int ELEM_W   = 32,
    parameter int NUM_ELEM = 8,
    localparam int CNT_W = $clog2(NUM_ELEM + 1),
    localparam int VEC_W = ELEM_W * NUM_ELEM
) (
    input logic                clk,
    input logic                rst_n,
    input logic                done_o,
    input logic                busy,
    input logic                load,
    input logic                cur_op,
    input logic [NUM_ELEM-1:0] cur_mask,
    input logic [VEC_W-1:0]    result_o,
    input logic [CNT_W-1:0]    packed_len_o
);
    // R7: done is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: done only follows a busy cycle
    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy));

    // R3: packed length equals population count of the held mask
    a_r3_len_popcount: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (32'(packed_len_o) == $countones(cur_mask)));

    // R4: top element is zero after a compress that did not fill the vector
    a_r4_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cur_op && (32'(packed_len_o) < NUM_ELEM))
            |-> (result_o[VEC_W-1 -: ELEM_W] == '0));

    // R8: operands stay fixed while an operation is in progress
    a_r8_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cur_mask) && $stable(cur_op)));

    // R9: idle without a new start keeps the outputs
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> ($stable(result_o) && $stable(packed_len_o)));
endmodule

bind vmask_pack_unit vmx_checker #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM)) u_chk (
    .clk(clk), .rst_n(rst_n), .done_o(done_o), .busy(busy), .load(load),
    .cur_op(cur_op), .cur_mask(cur_mask), .result_o(result_o),
    .packed_len_o(packed_len_o)
);

// File: tb/sim_vmask_pack_unit.sv
// Bench for the compress/expand unit: fixed-seed random operations mixed
// with directed masks, checked against reference functions.
module sim_vmask_pack_unit;
    localparam int W  = 32;
    localparam int N  = 8;
    localparam int VW = W * N;
    localparam int CW = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic opcode_i = 1'b0;
    logic [VW-1:0] src_i = '0;
    logic [VW-1:0] old_dst_i = '0;
    logic [N-1:0] mask_i = '0;
    logic done_o;
    logic [VW-1:0] result_o;
    logic [CW-1:0] packed_len_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    vmask_pack_unit #(.ELEM_W(W), .NUM_ELEM(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .src_i(src_i), .old_dst_i(old_dst_i), .mask_i(mask_i),
        .done_o(done_o), .result_o(result_o), .packed_len_o(packed_len_o)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run is a failure but still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    function automatic logic [VW-1:0] ref_compress(logic [VW-1:0] s, logic [N-1:0] m);
        logic [VW-1:0] r = '0;
        int k = 0;
        for (int i = 0; i < N; i++) begin
            if (m[i]) begin
                r[k*W +: W] = s[i*W +: W];
                k++;
            end
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] ref_expand(logic [VW-1:0] s, logic [VW-1:0] o,
                                                 logic [N-1:0] m);
        logic [VW-1:0] r = o;
        int k = 0;
        for (int i = 0; i < N; i++) begin
            if (m[i]) begin
                r[i*W +: W] = s[k*W +: W];
                k++;
            end
        end
        return r;
    endfunction

    function automatic int popcnt(logic [N-1:0] m);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = $urandom;
        return v;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation: start, wait for done, check result, pulse, latency, hold.
    task automatic run_op(input logic op, input logic [VW-1:0] s,
                          input logic [VW-1:0] o, input logic [N-1:0] m,
                          input bit intrude);
        logic [VW-1:0] exp_v;
        logic [VW-1:0] held;
        logic [CW-1:0] held_len;
        int cyc;
        exp_v = op ? ref_expand(s, o, m) : ref_compress(s, m);
        @(negedge clk);
        start_i = 1'b1; opcode_i = op; src_i = s; old_dst_i = o; mask_i = m;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (intrude && cyc == 3) begin
                start_i = 1'b1; opcode_i = ~op; src_i = rand_vec();
                old_dst_i = rand_vec(); mask_i = N'($urandom);
            end
            if (intrude && cyc == 4) start_i = 1'b0;
        end
        // R7: latency N+1 edges after the accepting edge
        check(cyc - 1 == N + 1, "R7 latency", VW'(cyc - 1), VW'(N + 1));
        if (op)
            check(result_o === exp_v, intrude ? "R8 R5,R6 expand" : "R5,R6 expand",
                  result_o, exp_v);
        else
            check(result_o === exp_v, intrude ? "R8 R2,R4 compress" : "R2,R4 compress",
                  result_o, exp_v);
        check(int'(packed_len_o) == popcnt(m), "R3 packed length",
              VW'(packed_len_o), VW'(popcnt(m)));
        held = result_o;
        held_len = packed_len_o;
        // R9: scramble data inputs while idle, outputs must hold
        src_i = rand_vec(); old_dst_i = rand_vec(); mask_i = N'($urandom);
        opcode_i = ~op;
        @(negedge clk);
        check(done_o == 1'b0, "R7 done single pulse", VW'(done_o), '0);
        @(negedge clk);
        @(negedge clk);
        check(result_o === held && packed_len_o === held_len, "R9 hold",
              result_o, held);
    endtask

    initial begin
        logic [N-1:0] dmask [6];
        void'($urandom(32'd20251));
        dmask[0] = 8'h00; dmask[1] = 8'hFF; dmask[2] = 8'h01;
        dmask[3] = 8'h80; dmask[4] = 8'hAA; dmask[5] = 8'h55;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(done_o == 1'b0, "R1 done after reset", VW'(done_o), '0);
        check(result_o === '0, "R1 result after reset", result_o, '0);
        check(packed_len_o === '0, "R1 length after reset", VW'(packed_len_o), '0);

        // Directed corner masks for both opcodes.
        for (int d = 0; d < 6; d++) begin
            run_op(1'b0, rand_vec(), rand_vec(), dmask[d], 1'b0);
            run_op(1'b1, rand_vec(), rand_vec(), dmask[d], 1'b0);
        end
        // R8: start during a run with all-set and all-clear masks
        run_op(1'b0, rand_vec(), rand_vec(), 8'hFF, 1'b1);
        run_op(1'b1, rand_vec(), rand_vec(), 8'h00, 1'b1);

        // Random operations, some with an intruding start.
        for (int t = 0; t < 80; t++) begin
            run_op(1'($urandom), rand_vec(), rand_vec(), N'($urandom), (t % 5) == 2);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule